// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the string of column addresses that a double-data-rate memory walks through during that burst. A one-cycle start strobe captures a starting column, a burst-length code and an ordering bit. From the next cycle on, the block puts out one column per clock, together with a valid flag. A last flag marks the final column of the burst.

Only the low field of the column changes inside a burst. That field is one bit wide for two beats, two bits wide for four beats and three bits wide for eight beats. In sequential ordering the field counts up from its start value and wraps inside the aligned block that the burst occupies. In interleaved ordering each beat XORs the start value with the beat index. Every bit above the field keeps its start value. A new burst may be launched during the last beat of the current one, so that bursts run back to back with no gap.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `valid_o` and `last_o` are low. Asserting reset in the middle of a burst ends that burst at once.
- R2: The length code on `blen_i` selects the beat count: 0 selects 2 beats, 1 selects 4 beats, and both 2 and 3 select 8 beats. `valid_o` rises in the cycle after the accepting clock edge. It then stays high for exactly that many consecutive cycles.
- R3: With `ilv_i` = 0 (sequential), beat i carries the low field equal to (start field + i) modulo the beat count. For example, 8 beats from 5 give 5,6,7,0,1,2,3,4, and 4 beats from 1 give 1,2,3,0.
- R4: With `ilv_i` = 1 (interleaved), beat i carries the low field equal to start field XOR i. For example, 8 beats from 5 give 5,4,7,6,1,0,3,2, and 4 beats from 1 give 1,0,3,2.
- R5: All column bits above the varying field (bits 0, 1:0 or 2:0 vary for 2, 4 or 8 beats) equal the start column on every beat.
- R6: The first beat of every burst carries the start column unchanged.
- R7: `last_o` is high on the final beat of a burst and on no other cycle.
- R8: A start presented while `last_o` is high is accepted, and its first beat appears in the very next cycle. With no start during the last beat, `valid_o` falls after that beat.
- R9: A start presented during a beat that is not the last one is ignored. The running burst continues unchanged.
- R10: The start column, length code and ordering bit are sampled only when a start is accepted. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch strobe for a burst |
| start_col_i | input | COL_W | First column of the burst |
| blen_i | input | 2 | Length code: 0 gives 2 beats, 1 gives 4 beats, 2 or 3 gives 8 beats |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column for the current beat; meaningful while `valid_o` is high |
| valid_o | output | 1 | A beat is on `col_o` |
| last_o | output | 1 | The current beat is the final one of its burst |

## Verification
A start that is high at a rising edge produces its first beat in the following cycle, because only the beat counter and the captured configuration sit between input and output. Beat i is therefore on the outputs i+1 cycles after the accepting edge. The bench raises `start_i` at a falling edge and samples every output at later falling edges. It reads beat i at the (i+1)-th falling edge after launch, and one edge further on it checks that the burst has ended, or for a chained burst that the new first beat is present. Start strobes that are meant to be ignored, and changes to the configuration inputs, are applied at a falling edge in mid-burst. Each one lasts a single cycle, and the outputs of the following beats are compared with the original burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Width of the widest varying field (8-beat burst)
  localparam int BEAT_W = 3;

  typedef enum logic [1:0] {
    BL_TWO       = 2'b00,
    BL_FOUR      = 2'b01,
    BL_EIGHT     = 2'b10,
    BL_EIGHT_ALT = 2'b11
  } blen_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } order_e;

  // Bits of the low field that move inside a burst of the given length
  function automatic logic [BEAT_W-1:0] field_mask(blen_e code);
    case (code)
      BL_TWO:  field_mask = 3'b001;
      BL_FOUR: field_mask = 3'b011;
      default: field_mask = 3'b111;
    endcase
  endfunction

  // Index of the final beat (beat count minus one)
  function automatic logic [BEAT_W-1:0] final_beat(blen_e code);
    case (code)
      BL_TWO:  final_beat = 3'd1;
      BL_FOUR: final_beat = 3'd3;
      default: final_beat = 3'd7;
    endcase
  endfunction

  // Low field for beat b of a burst starting at s
  function automatic logic [BEAT_W-1:0] beat_offset(
    logic [BEAT_W-1:0] s,
    logic [BEAT_W-1:0] b,
    logic [BEAT_W-1:0] m,
    order_e            ord
  );
    logic [BEAT_W-1:0] moved;
    moved = (ord == ORD_XOR) ? (s ^ b) : (s + b);
    beat_offset = (s & ~m) | (moved & m);
  endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_seq_pkg::*;
(
  input  blen_e             code_i,
  output logic [BEAT_W-1:0] mask_o,
  output logic [BEAT_W-1:0] final_o
);

  always_comb begin
    mask_o  = field_mask(code_i);
    final_o = final_beat(code_i);
  end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BEAT_W-1:0] final_d_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              at_last_o,
  output logic [BEAT_W-1:0] beat_o
);

  logic              busy_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] final_q;
  logic              at_last_w;
  logic              accept_w;

  assign at_last_w = busy_q && (beat_q == final_q);
  assign accept_w  = start_i && (!busy_q || at_last_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      beat_q  <= '0;
      final_q <= '0;
    end else if (accept_w) begin
      busy_q  <= 1'b1;
      beat_q  <= '0;
      final_q <= final_d_i;
    end else if (at_last_w) begin
      busy_q  <= 1'b0;
      beat_q  <= '0;
    end else if (busy_q) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign accept_o  = accept_w;
  assign busy_o    = busy_q;
  assign at_last_o = at_last_w;
  assign beat_o    = beat_q;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [COL_W-1:0]  col_d_i,
  input  logic [BEAT_W-1:0] mask_d_i,
  input  order_e            ord_d_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [COL_W-1:0]  col_o
);

  localparam int HI_W = COL_W - BEAT_W;

  logic [COL_W-1:0]  base_q;
  logic [BEAT_W-1:0] mask_q;
  order_e            ord_q;
  logic [BEAT_W-1:0] low_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      ord_q  <= ORD_SEQ;
    end else if (load_i) begin
      base_q <= col_d_i;
      mask_q <= mask_d_i;
      ord_q  <= ord_d_i;
    end
  end

  assign low_w = beat_offset(base_q[BEAT_W-1:0], beat_i, mask_q, ord_q);

  generate
    if (HI_W > 0) begin : g_upper
      assign col_o = {base_q[COL_W-1:BEAT_W], low_w};
    end else begin : g_narrow
      assign col_o = low_w[COL_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       blen_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic              accept_w;
  logic              busy_w;
  logic              at_last_w;
  logic [BEAT_W-1:0] beat_w;
  logic [BEAT_W-1:0] mask_d_w;
  logic [BEAT_W-1:0] final_d_w;

  burst_len_decode u_dec (
    .code_i  (blen_e'(blen_i)),
    .mask_o  (mask_d_w),
    .final_o (final_d_w)
  );

  burst_beat_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .final_d_i (final_d_w),
    .accept_o  (accept_w),
    .busy_o    (busy_w),
    .at_last_o (at_last_w),
    .beat_o    (beat_w)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept_w),
    .col_d_i  (start_col_i),
    .mask_d_i (mask_d_w),
    .ord_d_i  (order_e'(ilv_i)),
    .beat_i   (beat_w),
    .col_o    (col_o)
  );

  assign valid_o = busy_w;
  assign last_o  = at_last_w;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             accept_w,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);  // R7

  AST_FIRST_BEAT_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (valid_o && col_o == $past(start_col_i)));  // R6

  AST_UPPER_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> (valid_o && col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));  // R5

  AST_END_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);  // R8

  AST_CHAIN_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && start_i) |=> valid_o);  // R8

  AST_IDLE_START_LAUNCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && start_i) |=> valid_o);  // R2

  AST_MID_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |-> !accept_w);  // R9

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .accept_w    (accept_w),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;

  localparam int COL_W = 10;

  typedef struct packed {
    logic [9:0]  col;
    logic [1:0]  bl;
    logic        ilv;
    logic [31:0] exp;  // beat 0 in the top nibble
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{10'h005, 2'd2, 1'b0, 32'h56701234},
    '{10'h005, 2'd2, 1'b1, 32'h54761032},
    '{10'h001, 2'd1, 1'b0, 32'h12300000},
    '{10'h001, 2'd1, 1'b1, 32'h10320000},
    '{10'h3F6, 2'd1, 1'b0, 32'h67450000},
    '{10'h155, 2'd0, 1'b1, 32'h54000000},
    '{10'h0AB, 2'd2, 1'b1, 32'h32107654},
    '{10'h2C7, 2'd0, 1'b0, 32'h76000000},
    '{10'h2C7, 2'd3, 1'b0, 32'h70123456},
    '{10'h3F5, 2'd1, 1'b1, 32'h54760000}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [1:0]       blen_i = 2'd0;
  logic             ilv_i = 1'b0;
  wire  [COL_W-1:0] col_o;
  wire              valid_o;
  wire              last_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_i      (blen_i),
    .ilv_i       (ilv_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int beats_for(input logic [1:0] bl);
    return (bl == 2'd0) ? 2 : (bl == 2'd1) ? 4 : 8;
  endfunction

  // Reference: modulo walk for sequential, XOR for interleaved
  function automatic logic [9:0] ref_col(input logic [9:0] s, input logic [1:0] bl,
                                         input logic m, input int i);
    int n    = beats_for(bl);
    int lo   = int'(s) % n;
    int base = int'(s) - lo;
    if (m) return s ^ 10'(i);
    return 10'(base + ((lo + i) % n));
  endfunction

  task automatic launch(input logic [9:0] c, input logic [1:0] bl, input logic m);
    @(negedge clk);
    start_i     = 1'b1;
    start_col_i = c;
    blen_i      = bl;
    ilv_i       = m;
  endtask

  // Observe one burst launched at the previous falling edge.
  // poke_at >= 0: at that beat, drive disturbing inputs for one cycle.
  task automatic observe(input logic [9:0] c, input logic [1:0] bl, input logic m,
                         input bit use_tab, input logic [31:0] exp, input string tag,
                         input int poke_at, input bit poke_start, input bit tail);
    int n = beats_for(bl);
    for (int i = 0; i < n; i++) begin
      logic [9:0] e;
      @(negedge clk);
      if (i == 0) start_i = 1'b0;
      if (use_tab) e = {c[9:3], exp[4*(7-i) +: 3]};
      else         e = ref_col(c, bl, m, i);
      chk(tag, 32'(col_o), 32'(e));
      chk("R2 valid during burst", 32'(valid_o), 32'd1);
      chk("R7 last flag", 32'(last_o), 32'(i == n-1));
      chk("R5 upper bits", 32'(col_o[9:3]), 32'(c[9:3]));
      if (i == 0) chk("R6 first beat", 32'(col_o), 32'(c));
      if (i == poke_at) begin
        start_i     = poke_start;
        start_col_i = ~c;
        blen_i      = ~bl;
        ilv_i       = ~m;
      end else if (i == poke_at + 1) begin
        start_i = 1'b0;
      end
    end
    if (tail) begin
      @(negedge clk);
      chk("R2 burst ends", 32'(valid_o), 32'd0);
      chk("R7 no last when idle", 32'(last_o), 32'd0);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state, with a start held high during reset
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(valid_o), 32'd0);
    chk("R1 last in reset", 32'(last_o), 32'd0);
    start_i = 1'b0;
    rst_n   = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(valid_o), 32'd0);

    // Table of known sequences (R3 / R4, R2 code 3 in the table)
    for (int v = 0; v < NVEC; v++) begin
      launch(VEC[v].col, VEC[v].bl, VEC[v].ilv);
      observe(VEC[v].col, VEC[v].bl, VEC[v].ilv, 1'b1, VEC[v].exp,
              VEC[v].ilv ? "R4 table" : "R3 table", -1, 1'b0, 1'b1);
    end

    // Full sweep against the model
    for (int s = 0; s < 8; s++)
      for (int b = 0; b < 3; b++)
        for (int m = 0; m < 2; m++) begin
          logic [9:0] c = {7'(s*13 + b*5 + m*41), 3'(s)};
          launch(c, 2'(b), 1'(m));
          observe(c, 2'(b), 1'(m), 1'b0, 32'd0, m ? "R4 sweep" : "R3 sweep",
                  -1, 1'b0, 1'b1);
        end

    // R8: back-to-back bursts, start during last beat
    launch(10'h1E2, 2'd1, 1'b0);
    observe(10'h1E2, 2'd1, 1'b0, 1'b0, 32'd0, "R8 first burst", -1, 1'b0, 1'b0);
    start_i = 1'b1; start_col_i = 10'h09D; blen_i = 2'd2; ilv_i = 1'b1;
    observe(10'h09D, 2'd2, 1'b1, 1'b0, 32'd0, "R8 chained burst", -1, 1'b0, 1'b0);
    start_i = 1'b1; start_col_i = 10'h300; blen_i = 2'd0; ilv_i = 1'b0;
    observe(10'h300, 2'd0, 1'b0, 1'b0, 32'd0, "R8 second chain", -1, 1'b0, 1'b1);

    // R9: start during a middle beat is ignored
    launch(10'h012, 2'd2, 1'b0);
    observe(10'h012, 2'd2, 1'b0, 1'b0, 32'd0, "R9 mid-burst start", 2, 1'b1, 1'b1);

    // R10: inputs change without a start during a burst
    launch(10'h27B, 2'd1, 1'b1);
    observe(10'h27B, 2'd1, 1'b1, 1'b0, 32'd0, "R10 input change", 0, 1'b0, 1'b1);

    // R1: reset in the middle of a burst ends it
    launch(10'h044, 2'd2, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-burst", 32'(valid_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'(valid_o), 32'd0);

    summary();
    $finish;
  end

endmodule